// File: doc/BRIEF.md
# Global-History Branch Direction Predictor

This block guesses whether a conditional branch will be taken, using the branch's address together with the outcomes of the branches that came just before it. A shift register of recent outcomes is combined by XOR with a slice of the fetch address. The result selects one entry in a table of two-bit saturating counters, and the upper bit of that counter is the guess. The lookup is purely combinational, so the fetch stage gets its answer in the same cycle it presents the address.

When the branch later resolves, the pipeline returns the table index that the lookup produced, along with the real outcome. The block trains that exact counter and shifts the outcome into the history. Because the index comes back with the update, the counter that is trained belongs to the same pairing of history and address that made the guess, even if the history has moved since.

The current history is also visible at the ports. The pipeline can save it when it makes a guess and can write it back through a checkpoint-load input after a misprediction.

Top module: `gshare_dir_pred`

## Requirements
- R1: After reset the history is zero and every counter holds weakly not-taken (binary 01), so every lookup predicts not-taken.
- R2: The lookup index `fetch_idx` equals `fetch_hist` XOR `fetch_pc[HIST_W+1:2]`. Fetch address bits [1:0] and the bits above HIST_W+1 have no effect on the lookup.
- R3: Counter encoding is 00 strongly not-taken, 01 weakly not-taken, 10 weakly taken, 11 strongly taken. `fetch_taken` is 1 exactly when the bit 1 of the indexed counter is 1.
- R4: On a cycle with `res_valid` high, the counter at `res_idx` moves up one step if `res_taken` is 1 and down one step if it is 0. The new value is visible to lookups from the next cycle.
- R5: Counters saturate. A taken update leaves 11 at 11, and a not-taken update leaves 00 at 00.
- R6: A counter in a strong state changes its prediction only after two consecutive opposite outcomes. A single opposite outcome leaves the prediction unchanged.
- R7: On a resolution without a checkpoint load, the history shifts left by one bit. The outcome (1 = taken) enters bit 0 and the oldest bit is dropped.
- R8: With `res_valid` and `ckpt_load` both low, no counter and no history bit changes.
- R9: When `ckpt_load` is high, the history takes `ckpt_hist` on the next cycle. This has priority over the shift of R7, but a counter update on the same cycle is still applied.
- R10: An update changes only the counter at `res_idx`. All other entries keep their values.
- R11: `fetch_hist` shows the current history register at all times.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Active-low synchronous reset |
| fetch_pc | input | PC_W | Address of the branch being looked up |
| fetch_taken | output | 1 | Predicted direction, 1 = taken |
| fetch_idx | output | HIST_W | Table index used by this lookup, kept by the pipeline until resolution |
| fetch_hist | output | HIST_W | Current global history, for checkpointing |
| res_valid | input | 1 | A branch resolves this cycle |
| res_idx | input | HIST_W | Index that the resolving branch was predicted with |
| res_taken | input | 1 | Actual outcome of the resolving branch |
| ckpt_load | input | 1 | Overwrite the history with `ckpt_hist` |
| ckpt_hist | input | HIST_W | History value to restore |

## Verification
The hardest case to reach is training one chosen counter through all of its states. The history moves with every update, so a fixed address lands on a different entry each time. The stimulus therefore recomputes the fetch address before every step from the model's current history, which keeps the XOR pointed at the intended entry. This lets the hysteresis and saturation sequences run on a single counter. Full-table sweeps check that reset, idle cycles and neighbouring updates leave the other entries untouched. A long random phase, in which indices alias freely and checkpoint loads collide with resolutions, covers the rest.

// File: rtl/gshare_pkg.sv
package gshare_pkg;

  typedef enum logic [1:0] {
    CTR_SNT = 2'b00,
    CTR_WNT = 2'b01,
    CTR_WT  = 2'b10,
    CTR_ST  = 2'b11
  } ctr_e;

  localparam ctr_e CTR_RESET = CTR_WNT;

  // One training step of a saturating two-bit counter.
  function automatic ctr_e ctr_train(input ctr_e cur, input logic taken);
    ctr_e nxt;
    nxt = cur;
    if (taken) begin
      if (cur != CTR_ST) nxt = ctr_e'(cur + 2'd1);
    end else begin
      if (cur != CTR_SNT) nxt = ctr_e'(cur - 2'd1);
    end
    return nxt;
  endfunction

  // Direction encoded by a counter: its upper bit.
  function automatic logic ctr_predicts(input ctr_e cur);
    return cur[1];
  endfunction

endpackage

// File: rtl/gshare_idx_hash.sv
module gshare_idx_hash #(
  parameter int PC_W   = 32,
  parameter int HIST_W = 8
) (
  input  logic [PC_W-1:0]   pc,
  input  logic [HIST_W-1:0] hist,
  output logic [HIST_W-1:0] idx
);
  localparam int ALIGN_LSB = 2;
  localparam int UPPER_W   = PC_W - HIST_W - ALIGN_LSB;

  logic [HIST_W-1:0] pc_slice;
  logic              unused_pc_upper;
  logic              unused_pc_align;

  assign pc_slice        = pc[ALIGN_LSB +: HIST_W];
  assign idx             = pc_slice ^ hist;
  assign unused_pc_align = ^pc[ALIGN_LSB-1:0];

  generate
    if (UPPER_W > 0) begin : g_upper
      assign unused_pc_upper = ^pc[PC_W-1 -: UPPER_W];
    end else begin : g_no_upper
      assign unused_pc_upper = 1'b0;
    end
  endgenerate

endmodule

// File: rtl/gshare_ghr.sv
module gshare_ghr #(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              shift_en,
  input  logic              shift_bit,
  input  logic              load_en,
  input  logic [HIST_W-1:0] load_val,
  output logic [HIST_W-1:0] hist
);
  logic [HIST_W-1:0] hist_q;
  logic [HIST_W-1:0] hist_shifted;
  logic              hist_will_shift;

  assign hist_shifted    = {hist_q[HIST_W-2:0], shift_bit};
  assign hist_will_shift = shift_en && !load_en;

  always_ff @(posedge clk) begin
    if (!rst_n)               hist_q <= '0;
    else if (load_en)         hist_q <= load_val;
    else if (hist_will_shift) hist_q <= hist_shifted;
  end

  assign hist = hist_q;

  AST_GHR_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!shift_en && !load_en) |=> $stable(hist_q)); // R8
  AST_GHR_NEW_LSB: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load_en) |=> (hist_q[0] == $past(shift_bit))); // R7
  AST_GHR_AGE_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (shift_en && !load_en) |=> (hist_q[HIST_W-1:1] == $past(hist_q[HIST_W-2:0]))); // R7
  AST_GHR_RESTORE: assert property (@(posedge clk) disable iff (!rst_n)
    load_en |=> (hist_q == $past(load_val))); // R9

endmodule

// File: rtl/gshare_ctr_tbl.sv
module gshare_ctr_tbl
  import gshare_pkg::*;
#(
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [HIST_W-1:0] rd_idx,
  output ctr_e              rd_ctr,
  input  logic              wr_en,
  input  logic [HIST_W-1:0] wr_idx,
  input  logic              wr_taken
);
  localparam int DEPTH = 1 << HIST_W;

  ctr_e               ctr_q [DEPTH];
  logic [2*DEPTH-1:0] ctr_flat;
  ctr_e               wr_cur;
  ctr_e               wr_next;

  assign wr_cur  = ctr_q[wr_idx];
  assign wr_next = ctr_train(wr_cur, wr_taken);

  generate
    for (genvar i = 0; i < DEPTH; i++) begin : g_ent
      logic ent_hit;
      assign ent_hit = wr_en && (wr_idx == HIST_W'(i));

      always_ff @(posedge clk) begin
        if (!rst_n)       ctr_q[i] <= CTR_RESET;
        else if (ent_hit) ctr_q[i] <= wr_next;
      end

      assign ctr_flat[2*i +: 2] = ctr_q[i];

      AST_CTR_OTHERS_KEEP: assert property (@(posedge clk) disable iff (!rst_n)
        !(wr_en && wr_idx == HIST_W'(i)) |=> $stable(ctr_q[i])); // R10
    end
  endgenerate

  assign rd_ctr = ctr_q[rd_idx];

  AST_CTR_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(ctr_flat)); // R8
  AST_CTR_SAT_TOP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && ctr_q[wr_idx] == CTR_ST) |=> (ctr_q[$past(wr_idx)] == CTR_ST)); // R5
  AST_CTR_SAT_BOTTOM: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && ctr_q[wr_idx] == CTR_SNT) |=> (ctr_q[$past(wr_idx)] == CTR_SNT)); // R5
  AST_CTR_STEP_UP: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && wr_taken && ctr_q[wr_idx] != CTR_ST)
      |=> (2'(ctr_q[$past(wr_idx)]) == 2'($past(ctr_q[wr_idx]) + 2'd1))); // R4
  AST_CTR_STEP_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_en && !wr_taken && ctr_q[wr_idx] != CTR_SNT)
      |=> (2'(ctr_q[$past(wr_idx)]) == 2'($past(ctr_q[wr_idx]) - 2'd1))); // R4

endmodule

// File: rtl/gshare_dir_pred.sv
module gshare_dir_pred
  import gshare_pkg::*;
#(
  parameter int PC_W   = 32,
  parameter int HIST_W = 8
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [PC_W-1:0]   fetch_pc,
  output logic              fetch_taken,
  output logic [HIST_W-1:0] fetch_idx,
  output logic [HIST_W-1:0] fetch_hist,
  input  logic              res_valid,
  input  logic [HIST_W-1:0] res_idx,
  input  logic              res_taken,
  input  logic              ckpt_load,
  input  logic [HIST_W-1:0] ckpt_hist
);
  logic [HIST_W-1:0] ghr_now;
  logic [HIST_W-1:0] lookup_idx;
  ctr_e              lookup_ctr;
  logic              train_fire;

  assign train_fire = res_valid;

  gshare_ghr #(.HIST_W(HIST_W)) i_ghr (
    .clk       (clk),
    .rst_n     (rst_n),
    .shift_en  (train_fire),
    .shift_bit (res_taken),
    .load_en   (ckpt_load),
    .load_val  (ckpt_hist),
    .hist      (ghr_now)
  );

  gshare_idx_hash #(.PC_W(PC_W), .HIST_W(HIST_W)) i_hash (
    .pc   (fetch_pc),
    .hist (ghr_now),
    .idx  (lookup_idx)
  );

  gshare_ctr_tbl #(.HIST_W(HIST_W)) i_tbl (
    .clk      (clk),
    .rst_n    (rst_n),
    .rd_idx   (lookup_idx),
    .rd_ctr   (lookup_ctr),
    .wr_en    (train_fire),
    .wr_idx   (res_idx),
    .wr_taken (res_taken)
  );

  assign fetch_taken = ctr_predicts(lookup_ctr);
  assign fetch_idx   = lookup_idx;
  assign fetch_hist  = ghr_now;

  AST_IDX_ZERO_HIST: assert property (@(posedge clk) disable iff (!rst_n)
    (fetch_hist == '0) |-> (fetch_idx == fetch_pc[2 +: HIST_W])); // R2
  AST_RESET_NOT_TAKEN: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> !fetch_taken); // R1
  AST_RESET_HIST_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rst_n) |-> (fetch_hist == '0)); // R1

endmodule

// File: tb/test_gshare_dir_pred.sv
module test_gshare_dir_pred;
  localparam int CLK_PERIOD = 10;
  localparam int HW    = 8;
  localparam int PCW   = 32;
  localparam int DEPTH = 1 << HW;

  logic           clk = 1'b0;
  logic           rst_n = 1'b0;
  logic [PCW-1:0] fetch_pc = '0;
  logic           fetch_taken;
  logic [HW-1:0]  fetch_idx, fetch_hist;
  logic           res_valid = 1'b0;
  logic [HW-1:0]  res_idx = '0;
  logic           res_taken = 1'b0;
  logic           ckpt_load = 1'b0;
  logic [HW-1:0]  ckpt_hist = '0;

  int ref_ctr [DEPTH];
  int ref_hist;
  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  gshare_dir_pred #(.PC_W(PCW), .HIST_W(HW)) i_gshare_dir_pred (
    .clk(clk), .rst_n(rst_n), .fetch_pc(fetch_pc), .fetch_taken(fetch_taken),
    .fetch_idx(fetch_idx), .fetch_hist(fetch_hist), .res_valid(res_valid),
    .res_idx(res_idx), .res_taken(res_taken), .ckpt_load(ckpt_load),
    .ckpt_hist(ckpt_hist)
  );

  task automatic chk(input string tag, input string what, input int act, input int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
    end
  endtask

  // Address whose lookup lands on entry i under the model's current history,
  // with random alignment and upper bits that must not matter.
  function automatic logic [PCW-1:0] pc_for(input int i);
    logic [PCW-1:0] p;
    p = PCW'($urandom) << (HW + 2);
    p = p | PCW'(((i ^ ref_hist) & (DEPTH - 1)) << 2);
    p = p | PCW'($urandom & 3);
    return p;
  endfunction

  task automatic step(input logic [PCW-1:0] pc, input bit uv, input int uidx,
                      input bit ut, input bit lv, input int lval, input string tag);
    int exp_idx;
    @(negedge clk);
    fetch_pc  = pc;
    res_valid = uv;
    res_idx   = HW'(uidx);
    res_taken = ut;
    ckpt_load = lv;
    ckpt_hist = HW'(lval);
    #1;
    exp_idx = (int'(pc >> 2) ^ ref_hist) & (DEPTH - 1);
    chk(tag, "idx", int'(fetch_idx), exp_idx);
    chk(tag, "taken", int'(fetch_taken), (ref_ctr[exp_idx] >= 2) ? 1 : 0);
    chk(tag, "hist", int'(fetch_hist), ref_hist);
    @(posedge clk);
    if (uv) begin
      if (ut) ref_ctr[uidx] = (ref_ctr[uidx] < 3) ? ref_ctr[uidx] + 1 : 3;
      else    ref_ctr[uidx] = (ref_ctr[uidx] > 0) ? ref_ctr[uidx] - 1 : 0;
    end
    if (lv)      ref_hist = lval & (DEPTH - 1);
    else if (uv) ref_hist = ((ref_hist << 1) | int'(ut)) & (DEPTH - 1);
  endtask

  task automatic sweep(input string tag);
    for (int i = 0; i < DEPTH; i++) step(pc_for(i), 0, 0, 0, 0, 0, tag);
  endtask

  initial begin
    int tgt;
    int other;
    for (int i = 0; i < DEPTH; i++) ref_ctr[i] = 1;
    ref_hist = 0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1'b1;

    // R1: reset state, every entry predicts not-taken, history clear
    sweep("R1");

    // R3/R4: one taken step moves 01 to 10 and the upper bit flips the guess
    tgt = 8'h5a;
    step(pc_for(tgt), 1, tgt, 1, 0, 0, "R4");
    step(pc_for(tgt), 0, 0, 0, 0, 0, "R3");
    // R5: saturate at 11
    for (int k = 0; k < 3; k++) step(pc_for(tgt), 1, tgt, 1, 0, 0, "R5");
    // R6: first miss keeps taken, second flips
    step(pc_for(tgt), 1, tgt, 0, 0, 0, "R6");
    step(pc_for(tgt), 1, tgt, 0, 0, 0, "R6");
    step(pc_for(tgt), 0, 0, 0, 0, 0, "R6");
    // R5: saturate at 00, one taken only reaches 01
    for (int k = 0; k < 4; k++) step(pc_for(tgt), 1, tgt, 0, 0, 0, "R5");
    step(pc_for(tgt), 1, tgt, 1, 0, 0, "R5");
    step(pc_for(tgt), 0, 0, 0, 0, 0, "R5");

    // R7: shift a walking pattern through the full history width
    for (int k = 0; k < HW + 3; k++) step(pc_for(k), 1, k, (k % 3) == 0, 0, 0, "R7");

    // R8: idle cycles change nothing anywhere
    sweep("R8");

    // R9: restore alone, then restore colliding with a resolution
    step(pc_for(3), 0, 0, 0, 1, 8'hc3, "R9");
    step(pc_for(9), 1, 9, 1, 1, 8'h21, "R9");
    step(pc_for(9), 0, 0, 0, 0, 0, "R9");

    // R10: hammer one entry, neighbours must keep their state
    other = 8'h80;
    for (int k = 0; k < 6; k++) step(pc_for(other), 1, other, 1, 0, 0, "R10");
    sweep("R10");

    // R2/R11: random traffic with aliasing and checkpoint collisions
    for (int k = 0; k < 3000; k++) begin
      int u = int'($urandom_range(DEPTH - 1));
      step(PCW'($urandom), ($urandom % 4) != 0, (k % 5 == 0) ? 7 : u,
           ($urandom % 3) != 0, ($urandom % 16) == 0, int'($urandom_range(DEPTH - 1)),
           (k % 2) ? "R2" : "R11");
    end
    sweep("R11");

    done = 1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      fails++;
      $display("FAIL watchdog actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

endmodule